// File: doc/BRIEF.md
# Packed Lane Multiply-Accumulate Unit

This block is a single-stage arithmetic datapath for a 64-bit packed-data engine. Each accepted request carries two 64-bit operands, a 64-bit accumulator value and a 4-bit operation code. The operands are treated as four 16-bit lanes, as eight bytes, or as their low 32-bit word, depending on the code. The block computes one of several product or reduction functions and registers the 64-bit answer.

The functions fall into three families. Lane-wise products return a packed word. Pairwise and four-way reductions fold lane products into 32-bit or 64-bit sums. Accumulator forms add a product term to the supplied 64-bit accumulator. The signed and unsigned variants share one lane multiplier array, and a per-operation sign control sets how that array extends its inputs. Absolute-difference sums over bytes or halfwords have their own subtract tree. There is no saturation and no flag output. Wrap-around arithmetic is the defined behaviour.

A request is offered by raising `in_valid` for one cycle. The answer and `out_valid` appear after the next rising clock edge. Between requests the last answer is held.

Top module: `lane_mac_unit`

## Requirements
- R1: Codes 0 (signed) and 1 (unsigned) return, in each 16-bit lane k, bits 15:0 of the product of lane k of `opnd_a` and lane k of `opnd_b`.
- R2: Codes 2 (signed) and 3 (unsigned) return, in each 16-bit lane k, bits 31:16 of the 32-bit lane product, with operands taken as two's-complement for code 2 and as unsigned for code 3.
- R3: Codes 4 (signed) and 5 (unsigned) return in result[31:0] the sum of lane products 0 and 1, and in result[63:32] the sum of lane products 2 and 3. Each sum is truncated to 32 bits.
- R4: Code 7 returns the sum of the four unsigned lane products as a 64-bit value. Code 6 returns the sum of the four signed lane products, each sign-extended to 64 bits before the add.
- R5: Code 8 returns the sum of the eight absolute differences between corresponding unsigned bytes of the operands. The answer never exceeds 2040.
- R6: Code 9 returns the sum of the four absolute differences between corresponding unsigned halfwords. The answer never exceeds 262140.
- R7: Code 10 returns `acc_in` plus the signed 64-bit product of `opnd_a[31:0]` and `opnd_b[31:0]`, modulo 2^64.
- R8: Code 11 returns `acc_in` plus the sign-extended signed products of halfword 0 and of halfword 1 of the low operand words. Code 12 adds only the halfword-0 product. Both wrap modulo 2^64.
- R9: Codes 13, 14 and 15 return zero.
- R10: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, `result` keeps its previous value.
- R11: Synchronous active-high `rst` clears `out_valid` and `result` to zero on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured when high |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 64 | First packed operand |
| opnd_b | input | 64 | Second packed operand |
| acc_in | input | 64 | Accumulator value for codes 10 to 12 |
| out_valid | output | 1 | High for one cycle per accepted request |
| result | output | 64 | Registered answer |

## Verification
The bench drives lane values at the signed extremes (0x8000 against 0x8000 and against 0x7FFF) and all-ones patterns that an unsigned path must not sign-extend. A design that mixed up the sign control would flip the high halves in R2, would give a wrong upper word from the signed reduction in R4, and would make the accumulator forms of R8 add 2^32 too much. It also applies byte-level maximum differences for the absolute-difference sums, where a narrow adder drops the carry, and accumulator values near 2^64 that must wrap. Unused codes, hold cycles with no strobe, and a reset in the middle of traffic are mixed in, to catch a design that leaves stale data on the output or lets `out_valid` linger.

// File: rtl/lane_mac_pkg.sv
package lane_mac_pkg;

    localparam int WORD_W  = 64;
    localparam int LANE_W  = 16;
    localparam int NLANE   = WORD_W / LANE_W;
    localparam int BYTE_W  = 8;
    localparam int NBYTE   = WORD_W / BYTE_W;
    localparam int HALF_W  = WORD_W / 2;
    localparam int OPC_W   = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_MUL_LO_S = 4'd0,
        OPC_MUL_LO_U = 4'd1,
        OPC_MUL_HI_S = 4'd2,
        OPC_MUL_HI_U = 4'd3,
        OPC_PAIR_S   = 4'd4,
        OPC_PAIR_U   = 4'd5,
        OPC_RED_S    = 4'd6,
        OPC_RED_U    = 4'd7,
        OPC_SAD_B    = 4'd8,
        OPC_SAD_H    = 4'd9,
        OPC_ACC_W32  = 4'd10,
        OPC_ACC_H2   = 4'd11,
        OPC_ACC_H1   = 4'd12
    } mac_opc_e;

    typedef struct packed {
        mac_opc_e            opc;
        logic [WORD_W-1:0]   a;
        logic [WORD_W-1:0]   b;
        logic [WORD_W-1:0]   acc;
    } mac_req_t;

    // Whether an operation treats lane operands as two's complement.
    function automatic logic opc_signed(input mac_opc_e opc);
        case (opc)
            OPC_MUL_LO_S, OPC_MUL_HI_S, OPC_PAIR_S, OPC_RED_S,
            OPC_ACC_H2, OPC_ACC_H1: return 1'b1;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lane_mult_array.sv
module lane_mult_array #(
    parameter int LANE_W = 16,
    parameter int NLANE  = 4
) (
    input  logic [NLANE*LANE_W-1:0]         a,
    input  logic [NLANE*LANE_W-1:0]         b,
    input  logic                            sgn,
    output logic [NLANE-1:0][2*LANE_W-1:0]  prod
);
    localparam int EXT_W  = LANE_W + 1;
    localparam int FULL_W = 2 * EXT_W;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        logic signed [EXT_W-1:0]  xa;
        logic signed [EXT_W-1:0]  xb;
        logic signed [FULL_W-1:0] full;

        // One extra bit selects signed or unsigned interpretation.
        assign xa      = {sgn & a[k*LANE_W+LANE_W-1], a[k*LANE_W +: LANE_W]};
        assign xb      = {sgn & b[k*LANE_W+LANE_W-1], b[k*LANE_W +: LANE_W]};
        assign full    = xa * xb;
        assign prod[k] = full[2*LANE_W-1:0];
    end

endmodule

// File: rtl/abs_diff_sum.sv
module abs_diff_sum #(
    parameter int ELEM_W = 8,
    parameter int NELEM  = 8,
    parameter int SUM_W  = ELEM_W + $clog2(NELEM)
) (
    input  logic [NELEM*ELEM_W-1:0] a,
    input  logic [NELEM*ELEM_W-1:0] b,
    output logic [SUM_W-1:0]        sum
);
    logic [NELEM-1:0][ELEM_W-1:0] diff;

    for (genvar k = 0; k < NELEM; k++) begin : g_elem
        logic [ELEM_W-1:0] ea;
        logic [ELEM_W-1:0] eb;
        assign ea      = a[k*ELEM_W +: ELEM_W];
        assign eb      = b[k*ELEM_W +: ELEM_W];
        assign diff[k] = (ea >= eb) ? (ea - eb) : (eb - ea);
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < NELEM; k++) begin
            sum = sum + SUM_W'(diff[k]);
        end
    end

endmodule

// File: rtl/lane_mac_combine.sv
module lane_mac_combine
    import lane_mac_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int NLANE  = 4,
    parameter int WORD_W = NLANE * LANE_W,
    parameter int SADB_W = 11,
    parameter int SADH_W = 18
) (
    input  mac_opc_e                        opc,
    input  logic                            sgn,
    input  logic [NLANE-1:0][2*LANE_W-1:0]  prod,
    input  logic [WORD_W-1:0]               wide_prod,
    input  logic [WORD_W-1:0]               acc,
    input  logic [SADB_W-1:0]               sad_b,
    input  logic [SADH_W-1:0]               sad_h,
    output logic [WORD_W-1:0]               nxt
);
    localparam int PW    = 2 * LANE_W;
    localparam int NPAIR = NLANE / 2;

    logic [WORD_W-1:0]             lo_pack;
    logic [WORD_W-1:0]             hi_pack;
    logic [WORD_W-1:0]             pair_pack;
    logic [NLANE-1:0][WORD_W-1:0]  ext;
    logic [WORD_W-1:0]             red_sum;
    logic [WORD_W-1:0]             acc_h1;
    logic [WORD_W-1:0]             acc_h2;
    logic [WORD_W-1:0]             acc_w;

    for (genvar k = 0; k < NLANE; k++) begin : g_pack
        assign lo_pack[k*LANE_W +: LANE_W] = prod[k][LANE_W-1:0];
        assign hi_pack[k*LANE_W +: LANE_W] = prod[k][PW-1:LANE_W];
        assign ext[k] = {{(WORD_W-PW){sgn & prod[k][PW-1]}}, prod[k]};
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_pack[p*PW +: PW] = prod[2*p] + prod[2*p+1];
    end

    always_comb begin
        red_sum = '0;
        for (int k = 0; k < NLANE; k++) begin
            red_sum = red_sum + ext[k];
        end
    end

    assign acc_h1 = acc + ext[0];
    assign acc_h2 = acc_h1 + ext[1];
    assign acc_w  = acc + wide_prod;

    always_comb begin
        case (opc)
            OPC_MUL_LO_S, OPC_MUL_LO_U: nxt = lo_pack;
            OPC_MUL_HI_S, OPC_MUL_HI_U: nxt = hi_pack;
            OPC_PAIR_S,   OPC_PAIR_U:   nxt = pair_pack;
            OPC_RED_S,    OPC_RED_U:    nxt = red_sum;
            OPC_SAD_B:                  nxt = WORD_W'(sad_b);
            OPC_SAD_H:                  nxt = WORD_W'(sad_h);
            OPC_ACC_W32:                nxt = acc_w;
            OPC_ACC_H2:                 nxt = acc_h2;
            OPC_ACC_H1:                 nxt = acc_h1;
            default:                    nxt = '0;
        endcase
    end

endmodule

// File: rtl/lane_mac_unit.sv
module lane_mac_unit
    import lane_mac_pkg::*;
#(
    parameter int LANE_W = lane_mac_pkg::LANE_W,
    parameter int NLANE  = lane_mac_pkg::NLANE,
    parameter int BYTE_W = lane_mac_pkg::BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [3:0]                op_sel,
    input  logic [NLANE*LANE_W-1:0]   opnd_a,
    input  logic [NLANE*LANE_W-1:0]   opnd_b,
    input  logic [NLANE*LANE_W-1:0]   acc_in,
    output logic                      out_valid,
    output logic [NLANE*LANE_W-1:0]   result
);
    localparam int W      = NLANE * LANE_W;
    localparam int NB     = W / BYTE_W;
    localparam int HW     = W / 2;
    localparam int SADB_W = BYTE_W + $clog2(NB);
    localparam int SADH_W = LANE_W + $clog2(NLANE);

    mac_req_t                      req;
    logic                          sgn;
    logic [NLANE-1:0][2*LANE_W-1:0] prod;
    logic signed [W-1:0]           wide_prod;
    logic [SADB_W-1:0]             sad_b;
    logic [SADH_W-1:0]             sad_h;
    logic [W-1:0]                  nxt;

    assign req.opc = mac_opc_e'(op_sel);
    assign req.a   = opnd_a;
    assign req.b   = opnd_b;
    assign req.acc = acc_in;
    assign sgn     = opc_signed(req.opc);

    lane_mult_array #(.LANE_W(LANE_W), .NLANE(NLANE)) u_lanes (
        .a    (req.a),
        .b    (req.b),
        .sgn  (sgn),
        .prod (prod)
    );

    // Signed word product for the 32x32 accumulate form.
    assign wide_prod = $signed(req.a[HW-1:0]) * $signed(req.b[HW-1:0]);

    abs_diff_sum #(.ELEM_W(BYTE_W), .NELEM(NB), .SUM_W(SADB_W)) u_sad_b (
        .a   (req.a),
        .b   (req.b),
        .sum (sad_b)
    );

    abs_diff_sum #(.ELEM_W(LANE_W), .NELEM(NLANE), .SUM_W(SADH_W)) u_sad_h (
        .a   (req.a),
        .b   (req.b),
        .sum (sad_h)
    );

    lane_mac_combine #(
        .LANE_W (LANE_W),
        .NLANE  (NLANE),
        .WORD_W (W),
        .SADB_W (SADB_W),
        .SADH_W (SADH_W)
    ) u_comb (
        .opc       (req.opc),
        .sgn       (sgn),
        .prod      (prod),
        .wide_prod (wide_prod),
        .acc       (req.acc),
        .sad_b     (sad_b),
        .sad_h     (sad_h),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt;
            end
        end
    end

endmodule

// File: rtl/lane_mac_checker.sv
module lane_mac_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [3:0]   op_sel,
    input logic         out_valid,
    input logic [W-1:0] result
);
    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel >= 4'd13) |=> result == '0);

    assert_sadb_range_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 4'd8) |=> result <= 64'd2040);

    assert_sadh_range_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 4'd9) |=> result <= 64'd262140);

endmodule

bind lane_mac_unit lane_mac_checker #(.W(NLANE*LANE_W)) u_lane_mac_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_mac_unit_bench.sv
module lane_mac_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [63:0] acc_in = '0;
    logic        out_valid;
    logic [63:0] result;

    int vectors = 0;
    int miscompares = 0;

    bit          have_exp = 1'b0;
    bit          exp_valid = 1'b0;
    logic [63:0] exp_res = '0;
    string       exp_tag = "R11";

    always #5 clk = ~clk;

    lane_mac_unit u_lane_mac_unit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .acc_in    (acc_in),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic longint lv(input logic [15:0] x, input bit s);
        return s ? longint'($signed(x)) : longint'(x);
    endfunction

    function automatic logic [63:0] ref_fn(input logic [3:0] op, input logic [63:0] a,
                                            input logic [63:0] b, input logic [63:0] c);
        logic [63:0] r;
        longint p[4];
        bit s;
        longint tot;
        r = '0;
        s = (op == 0) || (op == 2) || (op == 4) || (op == 6) || (op == 11) || (op == 12);
        for (int k = 0; k < 4; k++) p[k] = lv(a[k*16 +: 16], s) * lv(b[k*16 +: 16], s);
        case (op)
            4'd0, 4'd1: for (int k = 0; k < 4; k++) r[k*16 +: 16] = p[k][15:0];
            4'd2, 4'd3: for (int k = 0; k < 4; k++) r[k*16 +: 16] = p[k][31:16];
            4'd4, 4'd5: begin
                tot = p[0] + p[1]; r[31:0]  = tot[31:0];
                tot = p[2] + p[3]; r[63:32] = tot[31:0];
            end
            4'd6, 4'd7: r = p[0] + p[1] + p[2] + p[3];
            4'd8: begin
                tot = 0;
                for (int k = 0; k < 8; k++) begin
                    int d;
                    d = int'(a[k*8 +: 8]) - int'(b[k*8 +: 8]);
                    tot += (d < 0) ? -d : d;
                end
                r = tot;
            end
            4'd9: begin
                tot = 0;
                for (int k = 0; k < 4; k++) begin
                    int d;
                    d = int'(a[k*16 +: 16]) - int'(b[k*16 +: 16]);
                    tot += (d < 0) ? -d : d;
                end
                r = tot;
            end
            4'd10: r = c + 64'(longint'($signed(a[31:0])) * longint'($signed(b[31:0])));
            4'd11: r = c + 64'(p[0]) + 64'(p[1]);
            4'd12: r = c + 64'(p[0]);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1:   return "R1";
            4'd2, 4'd3:   return "R2";
            4'd4, 4'd5:   return "R3";
            4'd6, 4'd7:   return "R4";
            4'd8:         return "R5";
            4'd9:         return "R6";
            4'd10:        return "R7";
            4'd11, 4'd12: return "R8";
            default:      return "R9";
        endcase
    endfunction

    task automatic compare();
        if (!have_exp) return;
        vectors++;
        if (out_valid !== exp_valid) begin
            miscompares++;
            $display("FAIL %s out_valid actual=%0b expected=%0b", exp_tag, out_valid, exp_valid);
        end
        if (result !== exp_res) begin
            miscompares++;
            $display("FAIL %s result actual=%h expected=%h", exp_tag, result, exp_res);
        end
    endtask

    task automatic step(input bit r, input bit v, input logic [3:0] op,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] c);
        @(negedge clk);
        compare();
        rst = r; in_valid = v; op_sel = op; opnd_a = a; opnd_b = b; acc_in = c;
        have_exp = 1'b1;
        if (r) begin
            exp_valid = 1'b0; exp_res = '0; exp_tag = "R11";
        end else if (v) begin
            exp_valid = 1'b1; exp_res = ref_fn(op, a, b, c); exp_tag = tag_of(op);
        end else begin
            exp_valid = 1'b0; exp_tag = "R10";
        end
    endtask

    function automatic logic [63:0] pick(input int sel);
        case (sel % 6)
            0: return {$urandom, $urandom};
            1: return 64'h8000_8000_8000_8000;
            2: return 64'h7FFF_7FFF_7FFF_7FFF;
            3: return 64'hFFFF_FFFF_FFFF_FFFF;
            4: return 64'h0000_0000_0000_0000;
            default: return {$urandom, $urandom} | 64'h8080_8080_8080_8080;
        endcase
    endfunction

    initial begin
        // R11: reset state, then release
        step(1'b1, 1'b0, 4'd0, '0, '0, '0);
        step(1'b1, 1'b0, 4'd0, '0, '0, '0);
        step(1'b0, 1'b0, 4'd0, '0, '0, '0);
        // Directed corners for every code (R1..R9)
        for (int op = 0; op < 16; op++) begin
            step(1'b0, 1'b1, 4'(op), 64'h8000_7FFF_FFFF_0001, 64'h8000_8000_FFFF_7FFF,
                 64'hFFFF_FFFF_FFFF_FFF0);
            step(1'b0, 1'b1, 4'(op), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000,
                 64'h0000_0000_0000_0005);
            step(1'b0, 1'b1, 4'(op), 64'h0102_FE7F_80FF_0010, 64'hFF01_02FE_0080_1000,
                 64'h8000_0000_0000_0000);
            // R10: idle cycle holds the previous answer
            step(1'b0, 1'b0, 4'(op), 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444, '0);
        end
        // R7: extreme signed word products with wrap of the accumulator
        step(1'b0, 1'b1, 4'd10, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000,
             64'hC000_0000_0000_0000);
        step(1'b0, 1'b1, 4'd10, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, '0);
        // Mixed random traffic with one reset in the middle
        for (int i = 0; i < 800; i++) begin
            bit v;
            v = ($urandom % 5) != 0;
            step(i == 400, v, 4'($urandom % 16), pick($urandom), pick($urandom),
                 {$urandom, $urandom});
        end
        step(1'b0, 1'b0, 4'd0, '0, '0, '0);
        step(1'b0, 1'b0, 4'd0, '0, '0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule